// File: doc/BRIEF.md
# Upstream packet aggregation controller

This block gathers completed USB IN packets into larger transfers before they are handed to a host-bound transfer engine. A strobe marks each packet that has finished, together with the packet's byte count. The block keeps a running packet count and byte total for the open aggregate. It raises a flush request when the aggregate is ready, and holds the total byte length steady until the transfer engine acknowledges it.

An aggregate closes on the first of these events:
- the programmed packet count is reached;
- a short packet arrives;
- one more full-size packet would no longer fit the selected host buffer;
- packed mode is selected, in which every packet goes out alone;
- an idle timeout expires, measured in 32-clock ticks from the most recent packet.

A master enable gates the whole function. Configuration is expected to change only while no aggregate is open.

Top module: `usb_aggr_ctrl`

## Requirements
- R1: After a synchronous reset, flush_req is 0 and flush_len is 0.
- R2: With cfg_max_aggr = N, an aggregate of full-size packets closes on packet N+1. The flush_req output is 1 one clock after that packet's strobe, with flush_len equal to the sum of the packet byte counts.
- R3: With cfg_max_aggr = 0, every accepted packet raises flush_req one clock after its strobe, with flush_len equal to that packet's byte count.
- R4: The full packet size is 64 bytes when cfg_hs = 0 and 512 bytes when cfg_hs = 1. A packet with fewer bytes than the full size closes the aggregate at once. A packet of exactly the full size does not close it.
- R5: cfg_buf_sel selects a host buffer of 4096 (00), 8192 (01), 16384 (10) or 32768 (11) bytes. The aggregate closes when its total plus one full-size packet would exceed that buffer.
- R6: With cfg_timeout = T > 0, an open aggregate that receives no packet is flushed after T ticks of 32 clocks. The request appears between 32·(T−1)+1 and 32·T clocks after the last packet's strobe cycle.
- R7: With cfg_timeout = 0, an open aggregate is never flushed by time alone.
- R8: cfg_packed = 1 selects packed mode, in which each packet is flushed alone. cfg_packed = 0 selects stream mode, in which packets aggregate.
- R9: While cfg_up_en = 0, flush_req stays 0, packet strobes are discarded and any open aggregate is dropped.
- R10: flush_req and flush_len hold steady until flush_ack is sampled high. flush_req is then 0 one clock later, and the packet count, byte total and timer restart from empty.
- R11: A packet strobe that arrives while flush_req is high is ignored and does not change flush_len.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | USB-side clock |
| rst | input | 1 | Synchronous reset, active high |
| pkt_done | input | 1 | One-cycle strobe: a packet has completed |
| pkt_bytes | input | 10 | Byte count of the completed packet |
| cfg_up_en | input | 1 | Upstream transfer enable |
| cfg_hs | input | 1 | Packet size select: 0 = 64 bytes, 1 = 512 bytes |
| cfg_packed | input | 1 | 0 = stream (aggregate), 1 = packed (one packet per transfer) |
| cfg_buf_sel | input | 2 | Host buffer size select |
| cfg_max_aggr | input | CNT_W | Packet limit minus one |
| cfg_timeout | input | TMO_W | Idle timeout in 32-clock ticks; 0 disables it |
| flush_ack | input | 1 | Transfer engine has taken the aggregate |
| flush_req | output | 1 | Aggregate ready for transfer |
| flush_len | output | 16 | Byte length of the aggregate |

## Verification
The close rules are driven one at a time with directed sequences. Full-size packet runs under different limits separate the count rule from the buffer rule, because at 512 bytes and a 4096-byte buffer the buffer rule closes first. A packet of exactly 64 bytes at full speed, followed by a 63-byte packet, separates a full packet from a short one. The timer is observed against its tick window, and it is also shown to stay silent when the timeout is 0. Randomised runs then mix packet sizes, speeds, buffer sizes and limits, so that the rules compete and a bench model decides which rule closes each aggregate and with how many bytes.

// File: rtl/usb_aggr_pkg.sv
package usb_aggr_pkg;

    localparam int LEN_W = 16;
    localparam int PKT_W = 10;
    localparam int PRE_W = 5;

    typedef enum logic [2:0] {
        CL_NONE,
        CL_COUNT,
        CL_SHORT,
        CL_BUF,
        CL_PACKED
    } close_e;

    typedef struct packed {
        logic       hs;
        logic       packed_mode;
        logic [1:0] buf_sel;
    } shape_t;

    function automatic logic [LEN_W:0] pkt_limit(input logic hs);
        return hs ? (LEN_W+1)'(512) : (LEN_W+1)'(64);
    endfunction

    function automatic logic [LEN_W:0] buf_limit(input logic [1:0] sel);
        return (LEN_W+1)'(4096) << sel;
    endfunction

endpackage

// File: rtl/aggr_prescale.sv
module aggr_prescale #(
    parameter int PRE_W = 5
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    logic [PRE_W-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst) div_q <= '0;
        else     div_q <= div_q + PRE_W'(1);
    end

    assign tick = &div_q;
endmodule

// File: rtl/aggr_idle_timer.sv
module aggr_idle_timer #(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             run,
    input  logic             tick,
    input  logic [TMO_W-1:0] limit,
    output logic             expire
);
    logic [TMO_W-1:0] ticks_q;

    assign expire = run && tick && ((ticks_q + TMO_W'(1)) == limit);

    always_ff @(posedge clk) begin
        if (rst || restart)    ticks_q <= '0;
        else if (run && tick)  ticks_q <= ticks_q + TMO_W'(1);
    end
endmodule

// File: rtl/aggr_close_rule.sv
module aggr_close_rule
    import usb_aggr_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  shape_t           shape,
    input  logic [CNT_W-1:0] max_aggr,
    input  logic [CNT_W:0]   next_cnt,
    input  logic [LEN_W-1:0] next_len,
    input  logic [PKT_W-1:0] bytes,
    output close_e           why
);
    logic [LEN_W:0] full_sz;
    logic [LEN_W:0] buf_sz;

    assign full_sz = pkt_limit(shape.hs);
    assign buf_sz  = buf_limit(shape.buf_sel);

    always_comb begin
        if (shape.packed_mode)
            why = CL_PACKED;
        else if (next_cnt == ({1'b0, max_aggr} + (CNT_W+1)'(1)))
            why = CL_COUNT;
        else if ((LEN_W+1)'(bytes) < full_sz)
            why = CL_SHORT;
        else if (({1'b0, next_len} + full_sz) > buf_sz)
            why = CL_BUF;
        else
            why = CL_NONE;
    end
endmodule

// File: rtl/usb_aggr_ctrl.sv
module usb_aggr_ctrl
    import usb_aggr_pkg::*;
#(
    parameter int CNT_W = 6,
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pkt_done,
    input  logic [9:0]       pkt_bytes,
    input  logic             cfg_up_en,
    input  logic             cfg_hs,
    input  logic             cfg_packed,
    input  logic [1:0]       cfg_buf_sel,
    input  logic [CNT_W-1:0] cfg_max_aggr,
    input  logic [TMO_W-1:0] cfg_timeout,
    input  logic             flush_ack,
    output logic             flush_req,
    output logic [15:0]      flush_len
);
    shape_t           shape;
    close_e           why;
    logic [CNT_W:0]   acc_cnt;
    logic [LEN_W-1:0] acc_len;
    logic             pend;
    logic             take;
    logic [CNT_W:0]   next_cnt;
    logic [LEN_W-1:0] next_len;
    logic             tick;
    logic             run;
    logic             restart;
    logic             expire;

    assign shape    = '{hs: cfg_hs, packed_mode: cfg_packed, buf_sel: cfg_buf_sel};
    assign take     = pkt_done && cfg_up_en && !pend;
    assign next_cnt = acc_cnt + (CNT_W+1)'(1);
    assign next_len = acc_len + LEN_W'(pkt_bytes);
    assign run      = cfg_up_en && !pend && (acc_cnt != '0) && (cfg_timeout != '0);
    assign restart  = take || !cfg_up_en || (pend && flush_ack);

    aggr_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    aggr_idle_timer #(.TMO_W(TMO_W)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .run     (run),
        .tick    (tick),
        .limit   (cfg_timeout),
        .expire  (expire)
    );

    aggr_close_rule #(.CNT_W(CNT_W)) u_rule (
        .shape    (shape),
        .max_aggr (cfg_max_aggr),
        .next_cnt (next_cnt),
        .next_len (next_len),
        .bytes    (pkt_bytes),
        .why      (why)
    );

    always_ff @(posedge clk) begin
        if (rst || !cfg_up_en) begin
            acc_cnt <= '0;
            acc_len <= '0;
            pend    <= 1'b0;
        end else if (pend) begin
            if (flush_ack) begin
                acc_cnt <= '0;
                acc_len <= '0;
                pend    <= 1'b0;
            end
        end else if (take) begin
            acc_cnt <= next_cnt;
            acc_len <= next_len;
            pend    <= (why != CL_NONE);
        end else if (expire) begin
            pend <= 1'b1;
        end
    end

    assign flush_req = pend;
    assign flush_len = acc_len;
endmodule

// File: rtl/aggr_checker.sv
module aggr_checker
    import usb_aggr_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             pkt_done,
    input logic             cfg_up_en,
    input logic [1:0]       cfg_buf_sel,
    input logic [CNT_W-1:0] cfg_max_aggr,
    input logic             flush_ack,
    input logic             flush_req,
    input logic [15:0]      flush_len
);
    p_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
        flush_req && !flush_ack && cfg_up_en |=> flush_req);

    p_len_stable_r10: assert property (@(posedge clk) disable iff (rst)
        flush_req && !flush_ack && cfg_up_en |=> $stable(flush_len));

    p_ack_clear_r10: assert property (@(posedge clk) disable iff (rst)
        flush_req && flush_ack |=> !flush_req);

    p_quiet_off_r9: assert property (@(posedge clk) disable iff (rst)
        !cfg_up_en |=> !flush_req);

    p_single_r3: assert property (@(posedge clk) disable iff (rst)
        cfg_up_en && (cfg_max_aggr == '0) && pkt_done && !flush_req |=> flush_req);

    p_fits_buf_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(flush_req) |-> ({1'b0, flush_len} <= buf_limit(cfg_buf_sel)));
endmodule

bind usb_aggr_ctrl aggr_checker #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .pkt_done     (pkt_done),
    .cfg_up_en    (cfg_up_en),
    .cfg_buf_sel  (cfg_buf_sel),
    .cfg_max_aggr (cfg_max_aggr),
    .flush_ack    (flush_ack),
    .flush_req    (flush_req),
    .flush_len    (flush_len)
);

// File: tb/test_usb_aggr_ctrl.sv
module test_usb_aggr_ctrl;
    localparam int CLK_P = 10;
    localparam int CNT_W = 6;
    localparam int TMO_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             pkt_done = 1'b0;
    logic [9:0]       pkt_bytes = '0;
    logic             cfg_up_en = 1'b0;
    logic             cfg_hs = 1'b0;
    logic             cfg_packed = 1'b0;
    logic [1:0]       cfg_buf_sel = '0;
    logic [CNT_W-1:0] cfg_max_aggr = '0;
    logic [TMO_W-1:0] cfg_timeout = '0;
    logic             flush_ack = 1'b0;
    logic             flush_req;
    logic [15:0]      flush_len;

    int vectors = 0;
    int misses  = 0;

    usb_aggr_ctrl #(.CNT_W(CNT_W), .TMO_W(TMO_W)) i_usb_aggr_ctrl (
        .clk          (clk),
        .rst          (rst),
        .pkt_done     (pkt_done),
        .pkt_bytes    (pkt_bytes),
        .cfg_up_en    (cfg_up_en),
        .cfg_hs       (cfg_hs),
        .cfg_packed   (cfg_packed),
        .cfg_buf_sel  (cfg_buf_sel),
        .cfg_max_aggr (cfg_max_aggr),
        .cfg_timeout  (cfg_timeout),
        .flush_ack    (flush_ack),
        .flush_req    (flush_req),
        .flush_len    (flush_len)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic int full_of(input bit hs);
        return hs ? 512 : 64;
    endfunction

    function automatic int buf_of(input int sel);
        return 4096 << sel;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input bit hs, input bit pk, input int bs, input int mx, input int to);
        cfg_hs       = hs;
        cfg_packed   = pk;
        cfg_buf_sel  = 2'(bs);
        cfg_max_aggr = CNT_W'(mx);
        cfg_timeout  = TMO_W'(to);
    endtask

    task automatic send_pkt(input int b);
        pkt_done  = 1'b1;
        pkt_bytes = 10'(b);
        @(negedge clk);
        pkt_done  = 1'b0;
    endtask

    task automatic expect_none(input string tag);
        chk(flush_req == 1'b0, tag, int'(flush_req), 0);
    endtask

    task automatic expect_flush(input int len, input string tag);
        chk(flush_req == 1'b1, tag, int'(flush_req), 1);
        chk(int'(flush_len) == len, tag, int'(flush_len), len);
        flush_ack = 1'b1;
        @(negedge clk);
        flush_ack = 1'b0;
        chk(flush_req == 1'b0, {tag, " ack clears"}, int'(flush_req), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        misses++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        int n;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(flush_req == 1'b0, "R1 req in reset", int'(flush_req), 0);
        rst = 1'b0;
        cfg_up_en = 1'b1;
        @(negedge clk);
        chk(flush_req == 1'b0 && flush_len == 16'd0, "R1 after reset", int'(flush_len), 0);

        // R3: limit 0 passes every packet through alone
        set_cfg(1, 0, 3, 0, 0);
        send_pkt(512);
        expect_flush(512, "R3 single");
        send_pkt(40);
        expect_flush(40, "R3 single short");

        // R2: N=2 closes on the third full packet
        set_cfg(0, 0, 0, 2, 0);
        send_pkt(64); expect_none("R2 pkt1");
        send_pkt(64); expect_none("R2 pkt2");
        send_pkt(64); expect_flush(192, "R2 pkt3");

        // R4: 64 bytes at full speed is full, 63 is short; 100 at high speed is short
        set_cfg(0, 0, 0, 3, 0);
        send_pkt(64); expect_none("R4 full 64");
        send_pkt(63); expect_flush(127, "R4 short 63");
        set_cfg(1, 0, 3, 20, 0);
        send_pkt(512); expect_none("R4 full 512");
        send_pkt(100); expect_flush(612, "R4 short 100");

        // R5: 4096-byte buffer closes after eight 512-byte packets
        set_cfg(1, 0, 0, 20, 0);
        for (int i = 0; i < 7; i++) begin
            send_pkt(512); expect_none("R5 below buffer");
        end
        send_pkt(512); expect_flush(4096, "R5 buffer full");

        // R8: packed mode flushes alone, stream mode aggregates
        set_cfg(1, 1, 3, 20, 0);
        send_pkt(512); expect_flush(512, "R8 packed");
        set_cfg(1, 0, 3, 20, 0);
        send_pkt(512); expect_none("R8 stream");
        send_pkt(5);   expect_flush(517, "R8 stream close");

        // R7: zero timeout never flushes by time
        set_cfg(1, 0, 3, 20, 0);
        send_pkt(512);
        repeat (300) @(negedge clk);
        expect_none("R7 no timeout");
        send_pkt(20); expect_flush(532, "R7 closed by short");

        // R6: timeout of 3 ticks
        set_cfg(1, 0, 3, 20, 3);
        send_pkt(512);
        n = 0;
        while (!flush_req && n < 200) begin
            @(negedge clk);
            n++;
        end
        chk(n >= 65 && n <= 96, "R6 timeout window", n, 96);
        expect_flush(512, "R6 timeout len");

        // R11: strobe during pending flush ignored
        set_cfg(1, 0, 3, 0, 0);
        send_pkt(512);
        send_pkt(100);
        chk(flush_len == 16'd512, "R11 len unchanged", int'(flush_len), 512);
        expect_flush(512, "R11 pending");
        // R10: after ack, a fresh aggregate starts empty
        send_pkt(30); expect_flush(30, "R10 restart empty");

        // R9: disabled block discards packets
        set_cfg(1, 0, 3, 0, 0);
        cfg_up_en = 1'b0;
        send_pkt(512);
        expect_none("R9 disabled no req");
        chk(flush_len == 16'd0, "R9 disabled len", int'(flush_len), 0);
        cfg_up_en = 1'b1;
        set_cfg(1, 0, 3, 20, 0);
        send_pkt(512); expect_none("R9 open");
        cfg_up_en = 1'b0;
        @(negedge clk);
        cfg_up_en = 1'b1;
        send_pkt(10); expect_flush(10, "R9 dropped aggregate");

        // Random mix of rules (R2 R4 R5) against a model
        for (int a = 0; a < 30; a++) begin
            bit hs;
            int bs, mx, ps, cnt, len;
            hs = 1'($urandom % 2);
            bs = int'($urandom % 4);
            mx = int'($urandom % 24);
            ps = full_of(hs);
            set_cfg(hs, 0, bs, mx, 0);
            cnt = 0;
            len = 0;
            for (int p = 0; p < 70; p++) begin
                int b;
                bit cl;
                b = (($urandom % 4) != 0) ? ps : 1 + int'($urandom % (ps - 1));
                send_pkt(b);
                cnt++;
                len += b;
                cl = (cnt == mx + 1) || (b < ps) || (len + ps > buf_of(bs));
                if (cl) begin
                    expect_flush(len, "R2/R4/R5 random close");
                    break;
                end
                expect_none("R2 random open");
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule